// File: doc/BRIEF.md
# Sticky Error Interrupt Status Register

This block collects three hardware error events (an uncorrectable memory error, a corrected memory error and a counter wrap) into a 64-bit status word. Each event is a pulse that sets its own status bit. The bit then stays set until software clears it. The word sits at one fixed offset on a simple register bus. Software reads it to learn which events have happened since the last clear.

Clearing works in the opposite sense to the common write-one-to-clear convention. Any status bit written with 0 is cleared, and any bit written with 1 is left alone. This lets software clear exactly the bits it has handled. A bus request is honoured only when it carries both the secure and the privileged attribute. Any other request to the register is refused with a one-cycle error response and zero read data.

A single interrupt line is formed from the status bits, each gated by its own enable input. The line is driven from a flip-flop, so it cannot glitch.

Top module: `err_irq_status`

## Requirements
- R1: After reset all status bits are 0, and `bus_rdata`, `bus_err` and `irq_out` are 0.
- R2: A one-cycle pulse on `evt_multi`, `evt_single` or `evt_ovfl` sets status bit 0, 1 or 2 respectively. A permitted read returns the status word on `bus_rdata` in the cycle after the read request.
- R3: A set status bit stays set on later cycles until a permitted write clears it.
- R4: On a permitted write to offset 0x30198, a write-data bit of 0 clears the matching status bit in bits 2:0. A write-data bit of 1 leaves that status bit as it was.
- R5: Bits 63:3 of the read data are always 0, whatever value was written to them.
- R6: A request to the register that is not both secure (`bus_secure`=1) and privileged (`bus_priv`=1) leaves the status unchanged. In the following cycle it returns zero read data and drives `bus_err` high for that cycle only.
- R7: If an event and a clear of the same bit fall in the same cycle, the bit ends that cycle set. An event input held high sets its bit again on every cycle.
- R8: `irq_out` goes high one cycle after any status bit i is 1 while `irq_en[i]`=1, and is 0 when no enabled status bit is set.
- R9: A write to any other address does not change the status. A read of any other address returns 0 with `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 20 | Byte offset of the request |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 64 | Write data |
| bus_secure | input | 1 | Request carries the secure attribute |
| bus_priv | input | 1 | Request carries the privileged attribute |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| bus_err | output | 1 | Error response, one cycle after a refused request |
| evt_multi | input | 1 | Uncorrectable memory error pulse |
| evt_single | input | 1 | Corrected memory error pulse |
| evt_ovfl | input | 1 | Event counter wrap pulse |
| irq_en | input | 3 | Per-bit interrupt enable |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A status change lands on the clock edge that samples the event or the write. Read data and the error response appear one edge after the request. The interrupt line follows one edge after the status, so it is two edges after the event pulse. The bench drives every input on the falling edge and samples on the next falling edge. A status update is therefore always checked through a separate read cycle, and the bench looks at the interrupt line both before and after its extra register stage.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
    localparam int STS_W  = 64;
    localparam int EVT_N  = 3;
    localparam int ADDR_W = 20;

    typedef enum int unsigned {
        EV_MULTI  = 0,
        EV_SINGLE = 1,
        EV_OVFL   = 2
    } evt_idx_e;
endpackage

// File: rtl/irqstat_gate.sv
module irqstat_gate #(
    parameter int              ADDR_W = 20,
    parameter int              DATA_W = 64,
    parameter int              EVT_N  = 3,
    parameter logic [ADDR_W-1:0] OFFSET = ADDR_W'('h30198)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [EVT_N-1:0]  wkeep_i,
    input  logic              sec_i,
    input  logic              priv_i,
    input  logic [EVT_N-1:0]  sts_i,
    output logic              clr_en_o,
    output logic [EVT_N-1:0]  clr_keep_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } gate_t;

    gate_t st_d, st_q;
    logic  hit, allowed, req;

    always_comb begin
        hit        = (addr_i == OFFSET);
        allowed    = sec_i & priv_i;
        req        = wr_i | rd_i;
        clr_en_o   = wr_i & hit & allowed;
        clr_keep_o = wkeep_i;
        st_d       = '0;
        if (rd_i && hit && allowed) begin
            st_d.rdata = DATA_W'(sts_i);
        end
        st_d.err = req & hit & ~allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign err_o   = st_q.err;

    // R6: refused access answers with an error and zero data
    a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_i || rd_i) && addr_i == OFFSET && !(sec_i && priv_i))
        |=> (err_o && rdata_o == '0));

    // R9: other addresses read zero without error
    a_r9_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_i || rd_i) && addr_i != OFFSET) |=> (!err_o && rdata_o == '0));
endmodule

// File: rtl/irqstat_sticky.sv
module irqstat_sticky #(
    parameter int EVT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             clr_en_i,
    input  logic [EVT_N-1:0] clr_keep_i,
    output logic [EVT_N-1:0] sts_o
);
    typedef struct packed {
        logic [EVT_N-1:0] sts;
    } sticky_t;

    sticky_t st_d, st_q;
    logic [EVT_N-1:0] keep_mask;

    always_comb begin
        keep_mask = clr_en_i ? clr_keep_i : '1;
        st_d.sts  = (st_q.sts & keep_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;

    for (genvar i = 0; i < EVT_N; i++) begin : g_chk
        // R7: an event always leaves its bit set
        a_r7_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> sts_o[i]);
        // R3: set bit holds without a clear
        a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_o[i] && !(clr_en_i && !clr_keep_i[i])) |=> sts_o[i]);
        // R4: zero in write data clears when no event
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && !clr_keep_i[i] && !evt_i[i]) |=> !sts_o[i]);
    end
endmodule

// File: rtl/irqstat_irq.sv
module irqstat_irq #(
    parameter int EVT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] sts_i,
    input  logic [EVT_N-1:0] en_i,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d.irq = |(sts_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R8: enabled status raises the line one cycle later
    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_i & en_i)) |=> irq_o);
    // R8: line drops when nothing enabled is set
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/err_irq_status.sv
module err_irq_status
    import irqstat_pkg::*;
#(
    parameter int                AW     = ADDR_W,
    parameter int                DW     = STS_W,
    parameter int                NE     = EVT_N,
    parameter logic [AW-1:0]     OFFSET = AW'('h30198)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_secure,
    input  logic          bus_priv,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    input  logic          evt_multi,
    input  logic          evt_single,
    input  logic          evt_ovfl,
    input  logic [NE-1:0] irq_en,
    output logic          irq_out
);
    logic [NE-1:0] evt_vec;
    logic [NE-1:0] sts;
    logic [NE-1:0] clr_keep;
    logic          clr_en;

    always_comb begin
        evt_vec                  = '0;
        evt_vec[int'(EV_MULTI)]  = evt_multi;
        evt_vec[int'(EV_SINGLE)] = evt_single;
        evt_vec[int'(EV_OVFL)]   = evt_ovfl;
    end

    irqstat_gate #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .EVT_N  (NE),
        .OFFSET (OFFSET)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .wkeep_i    (bus_wdata[NE-1:0]),
        .sec_i      (bus_secure),
        .priv_i     (bus_priv),
        .sts_i      (sts),
        .clr_en_o   (clr_en),
        .clr_keep_o (clr_keep),
        .rdata_o    (bus_rdata),
        .err_o      (bus_err)
    );

    irqstat_sticky #(
        .EVT_N (NE)
    ) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_vec),
        .clr_en_i   (clr_en),
        .clr_keep_i (clr_keep),
        .sts_o      (sts)
    );

    irqstat_irq #(
        .EVT_N (NE)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sts_i (sts),
        .en_i  (irq_en),
        .irq_o (irq_out)
    );

    // R5: reserved bits never read as one
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NE] == '0);

    // R6: a refused write does not touch the status
    a_r6_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(bus_secure && bus_priv) && evt_vec == '0) |=> $stable(sts));
endmodule

// File: tb/sim_err_irq_status.sv
module sim_err_irq_status;
    localparam logic [19:0] OFF  = 20'h30198;
    localparam int          NVEC = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic        bus_secure = 1'b0, bus_priv = 1'b0;
    logic [63:0] bus_rdata;
    logic        bus_err;
    logic        evt_multi = 1'b0, evt_single = 1'b0, evt_ovfl = 1'b0;
    logic [2:0]  irq_en = 3'b111;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    err_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_multi(evt_multi), .evt_single(evt_single), .evt_ovfl(evt_ovfl),
        .irq_en(irq_en), .irq_out(irq_out)
    );

    // {evt[2:0], wr, wkeep[2:0], sec, priv, exp_err, exp_sts[2:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {3'b001, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 3'b001},
        {3'b000, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 3'b001},
        {3'b110, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 3'b111},
        {3'b000, 1'b1, 3'b101, 1'b1, 1'b1, 1'b0, 3'b101},
        {3'b000, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b101},
        {3'b000, 1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 3'b101},
        {3'b000, 1'b1, 3'b000, 1'b1, 1'b0, 1'b1, 3'b101},
        {3'b001, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 3'b001},
        {3'b000, 1'b1, 3'b110, 1'b1, 1'b1, 1'b0, 3'b000},
        {3'b010, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 3'b010},
        {3'b000, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 3'b000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request cycle from a falling edge, return on the next falling edge
    task automatic op(input logic wr, input logic rd, input logic [19:0] a,
                      input logic [63:0] wd, input logic sec, input logic prv,
                      input logic [2:0] evt);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        bus_secure = sec; bus_priv = prv;
        {evt_ovfl, evt_single, evt_multi} = evt;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        bus_secure = 1'b0; bus_priv = 1'b0;
        {evt_ovfl, evt_single, evt_multi} = 3'b000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", bus_rdata, 64'h0);
        chk("R1 err", {63'h0, bus_err}, 64'h0);
        chk("R1 irq", {63'h0, irq_out}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R1 status read", bus_rdata, 64'h0);

        // table walk: R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            op(v[9], 1'b0, OFF, {{61{1'b1}}, v[8:6]}, v[5], v[4], v[12:10]);
            chk($sformatf("R6 err vec %0d", i), {63'h0, bus_err}, {63'h0, v[3]});
            op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
            chk($sformatf("R2/R4/R7 status vec %0d", i), bus_rdata, {61'h0, v[2:0]});
            chk($sformatf("R8 irq vec %0d", i), {63'h0, irq_out}, {63'h0, |v[2:0]});
        end

        // R8: interrupt is one cycle behind the status
        op(1'b0, 1'b0, OFF, 64'h0, 1'b0, 1'b0, 3'b001);
        chk("R8 irq not yet", {63'h0, irq_out}, 64'h0);
        @(negedge clk);
        chk("R8 irq raised", {63'h0, irq_out}, 64'h1);
        irq_en = 3'b110;
        @(negedge clk);
        chk("R8 masked", {63'h0, irq_out}, 64'h0);
        irq_en = 3'b001;
        @(negedge clk);
        chk("R8 enabled", {63'h0, irq_out}, 64'h1);
        irq_en = 3'b111;

        // R5: upper bits stay zero after writing all ones
        op(1'b1, 1'b0, OFF, {64{1'b1}}, 1'b1, 1'b1, 3'b000);
        op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R5 upper zero", bus_rdata, 64'h1);

        // R6: refused read returns zero, error lasts one cycle
        op(1'b0, 1'b1, OFF, 64'h0, 1'b0, 1'b1, 3'b000);
        chk("R6 refused rdata", bus_rdata, 64'h0);
        chk("R6 refused err", {63'h0, bus_err}, 64'h1);
        @(negedge clk);
        chk("R6 err one cycle", {63'h0, bus_err}, 64'h0);

        // R9: other address
        op(1'b1, 1'b0, OFF + 20'h8, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R9 write err", {63'h0, bus_err}, 64'h0);
        op(1'b0, 1'b1, OFF + 20'h8, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R9 read other", bus_rdata, 64'h0);
        chk("R9 read other err", {63'h0, bus_err}, 64'h0);
        op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R9 status kept", bus_rdata, 64'h1);

        // R7: held event survives repeated clears
        for (int k = 0; k < 3; k++) begin
            op(1'b1, 1'b0, OFF, 64'h0, 1'b1, 1'b1, 3'b010);
        end
        op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R7 held event", bus_rdata, 64'h2);

        // R3: status holds over idle cycles
        repeat (4) @(negedge clk);
        op(1'b0, 1'b1, OFF, 64'h0, 1'b1, 1'b1, 3'b000);
        chk("R3 hold idle", bus_rdata, 64'h2);

        finish_run();
    end
endmodule